// File: doc/BRIEF.md
# Banked Reset Line Controller With Completion Status

This block holds the reset requests for up to 128 reset lines and reports when each request has taken effect. The lines are grouped into four banks of 32. Software writes a 1 into a line's request bit to hold that line in reset, and a 0 to release it. Each line has its own clock-enable input, `line_clk_en`, that stands in for that line's clock. The request passes through a two-stage synchronizer that advances only on cycles where that enable is high. The synchronized value drives the line's reset output and also feeds the status word that software reads back.

Most lines report status as 1 when released and 0 when held. A fixed handful of lines report the opposite sense. When a line's clock is gated, its status stays where it is. Software therefore polls the status word against the expected encoding, and must give up after a bounded number of polls.

Register access is a plain single-cycle port with no handshake:
- Writes take effect on the clock edge where `wr_en` is high.
- `rd_data` is a combinational function of `addr` and the current state.
- Only `addr[5:2]` selects a word; the two low address bits are ignored.

Top module: `line_reset_ctrl`

## Requirements
- R1: After `rst_n` is low, every request bit reads 0, every `line_in_reset` bit is 0, and every status word reads the released encoding.
- R2: Word `b` (byte offset 4·b, b = 0..3) holds the request bits of lines 32·b..32·b+31, with line N at bit N%32. A write there is visible on the next cycle, and reads return the last value written.
- R3: Word 4+b (byte offset 0x10+4·b) reads the status of the same 32 lines, using the same bit mapping.
- R4: A normal line reads status 0 while held and 1 while released. The inverted lines read 1 while held and 0 while released. The inverted lines are bank 0 bits 0, 3 and 5; bank 1 bits 6 and 7; and bank 2 bit 16. Bank 3 has no inverted lines.
- R5: A line's output and status take a new request value on the second rising edge, counting only edges where that line's enable is high, that follows the edge which wrote the request. They never change before that edge.
- R6: While a line's enable is low, its output and status do not change, so a release or an assert never completes.
- R7: Writes to status words or to unmapped words (word index 8..15) change nothing. Unmapped words read 0.
- R8: Each line follows its own request and enable, independently of all other lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset of the whole controller |
| wr_en | input | 1 | Write strobe for the word selected by `addr` |
| addr | input | 6 | Byte address; bits 5:2 select the word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| line_clk_en | input | 128 | Per-line clock enable; bit N gates line N |
| line_in_reset | output | 128 | Synchronized reset state; 1 means line N is held |

## Verification
Directed sequences cover several cases:
- Reset state.
- A single-bank write with every enable high, checked cycle by cycle. This separates a one-tick path from the required two-tick path.
- A line whose enable stays low for many cycles, which shows that a stalled release never completes.
- Setting every line at once, which exposes each inverted status bit against its normal neighbours.
- Writes aimed at status and unmapped words, which must leave the request words untouched.

Random traffic then mixes writes to all sixteen words with randomly gated enables. The request, status and unmapped words, and the line outputs, are compared every cycle against a bench model. This catches crosstalk between lines or banks and any address-decode aliasing.

// File: rtl/rstc_pkg.sv
`timescale 1ns/1ps
package rstc_pkg;
  localparam int RSTC_BANKS  = 4;
  localparam int RSTC_BANK_W = 32;

  typedef enum logic [1:0] {
    RGN_REQ    = 2'd0,
    RGN_STATUS = 2'd1,
    RGN_NONE   = 2'd2
  } rstc_region_e;

  // Lines whose status reads 1 while held in reset.
  function automatic logic [RSTC_BANKS*RSTC_BANK_W-1:0] rstc_inv_default();
    logic [RSTC_BANKS*RSTC_BANK_W-1:0] m;
    m = '0;
    m[0]  = 1'b1;
    m[3]  = 1'b1;
    m[5]  = 1'b1;
    m[38] = 1'b1;
    m[39] = 1'b1;
    m[80] = 1'b1;
    return m;
  endfunction

  localparam logic [RSTC_BANKS*RSTC_BANK_W-1:0] RSTC_INV_DEFAULT = rstc_inv_default();
endpackage

// File: rtl/rstc_addr_decode.sv
`timescale 1ns/1ps
module rstc_addr_decode
  import rstc_pkg::*;
#(
  parameter int NUM_BANKS = RSTC_BANKS,
  parameter int ADDR_W    = 6,
  localparam int WORD_W   = ADDR_W - 2,
  localparam int BIDX_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output rstc_region_e      region,
  output logic [BIDX_W-1:0] bank
);
  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] word_off;

  always_comb begin
    word     = addr[ADDR_W-1:2];
    word_off = word - WORD_W'(NUM_BANKS);
    region   = RGN_NONE;
    bank     = '0;
    if (word < WORD_W'(NUM_BANKS)) begin
      region = RGN_REQ;
      bank   = word[BIDX_W-1:0];
    end else if (word < WORD_W'(2 * NUM_BANKS)) begin
      region = RGN_STATUS;
      bank   = word_off[BIDX_W-1:0];
    end
  end
endmodule

// File: rtl/rstc_req_regs.sv
`timescale 1ns/1ps
module rstc_req_regs
  import rstc_pkg::*;
#(
  parameter int NUM_BANKS = RSTC_BANKS,
  parameter int BANK_W    = RSTC_BANK_W,
  localparam int NUM_LINES = NUM_BANKS * BANK_W,
  localparam int BIDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  rstc_region_e         region,
  input  logic [BIDX_W-1:0]    bank,
  input  logic [BANK_W-1:0]    wr_data,
  output logic [NUM_LINES-1:0] req
);
  logic [BANK_W-1:0] bank_q [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bank_q[b] <= '0;
      end else if (wr_en && region == RGN_REQ && bank == BIDX_W'(b)) begin
        bank_q[b] <= wr_data;
      end
    end
    assign req[b*BANK_W +: BANK_W] = bank_q[b];
  end

  AST_REQ_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && region == RGN_REQ) |=> bank_q[$past(bank)] == $past(wr_data)); // R2

  AST_RO_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && region != RGN_REQ) |=> $stable(req)); // R7
endmodule

// File: rtl/rstc_line_sync.sv
`timescale 1ns/1ps
module rstc_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic req_in,
  output logic held_out
);
  logic mid_q;
  logic out_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mid_q <= 1'b0;
      out_q <= 1'b0;
    end else if (tick_en) begin
      mid_q <= req_in;
      out_q <= mid_q;
    end
  end

  assign held_out = out_q;

  AST_GATED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(out_q)); // R6

  AST_OUT_FROM_MID: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_q) |-> out_q == $past(mid_q)); // R5
endmodule

// File: rtl/rstc_readback.sv
`timescale 1ns/1ps
module rstc_readback
  import rstc_pkg::*;
#(
  parameter int NUM_BANKS = RSTC_BANKS,
  parameter int BANK_W    = RSTC_BANK_W,
  parameter logic [NUM_BANKS*BANK_W-1:0] INV_MASK = RSTC_INV_DEFAULT,
  localparam int NUM_LINES = NUM_BANKS * BANK_W,
  localparam int BIDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  rstc_region_e         region,
  input  logic [BIDX_W-1:0]    bank,
  input  logic [NUM_LINES-1:0] req,
  input  logic [NUM_LINES-1:0] held,
  output logic [BANK_W-1:0]    rd_data
);
  logic [BANK_W-1:0] req_w  [NUM_BANKS];
  logic [BANK_W-1:0] stat_w [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_view
    assign req_w[b]  = req[b*BANK_W +: BANK_W];
    assign stat_w[b] = held[b*BANK_W +: BANK_W] ^ ~INV_MASK[b*BANK_W +: BANK_W];
  end

  always_comb begin
    unique case (region)
      RGN_REQ:    rd_data = req_w[bank];
      RGN_STATUS: rd_data = stat_w[bank];
      default:    rd_data = '0;
    endcase
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (region == RGN_NONE) |-> rd_data == '0); // R7
endmodule

// File: rtl/line_reset_ctrl.sv
`timescale 1ns/1ps
module line_reset_ctrl
  import rstc_pkg::*;
#(
  parameter int NUM_BANKS = RSTC_BANKS,
  parameter int BANK_W    = RSTC_BANK_W,
  parameter int ADDR_W    = 6,
  parameter logic [NUM_BANKS*BANK_W-1:0] INV_MASK = RSTC_INV_DEFAULT,
  localparam int NUM_LINES = NUM_BANKS * BANK_W,
  localparam int BIDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [BANK_W-1:0]    wr_data,
  output logic [BANK_W-1:0]    rd_data,
  input  logic [NUM_LINES-1:0] line_clk_en,
  output logic [NUM_LINES-1:0] line_in_reset
);
  rstc_region_e         region;
  logic [BIDX_W-1:0]    bank;
  logic [NUM_LINES-1:0] req;

  rstc_addr_decode #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_dec (
    .addr   (addr),
    .region (region),
    .bank   (bank)
  );

  rstc_req_regs #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .region  (region),
    .bank    (bank),
    .wr_data (wr_data),
    .req     (req)
  );

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    rstc_line_sync u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_en  (line_clk_en[n]),
      .req_in   (req[n]),
      .held_out (line_in_reset[n])
    );
  end

  rstc_readback #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .INV_MASK(INV_MASK)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .region  (region),
    .bank    (bank),
    .req     (req),
    .held    (line_in_reset),
    .rd_data (rd_data)
  );
endmodule

// File: tb/tb_line_reset_ctrl.sv
`timescale 1ns/1ps
module tb_line_reset_ctrl;
  localparam int NL = 128;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [5:0]    addr = '0;
  logic [31:0]   wr_data = '0;
  logic [31:0]   rd_data;
  logic [NL-1:0] line_clk_en = '1;
  logic [NL-1:0] line_in_reset;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  bit          done = 1'b0;

  logic [NL-1:0] m_req = '0;
  logic [NL-1:0] m_mid = '0;
  logic [NL-1:0] m_out = '0;

  always #2.5 clk = ~clk;

  line_reset_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .line_clk_en(line_clk_en), .line_in_reset(line_in_reset)
  );

  // R4: the inverted-polarity lines, taken from the requirement
  function automatic logic [NL-1:0] inv_lines();
    logic [NL-1:0] m = '0;
    m[0] = 1; m[3] = 1; m[5] = 1;
    m[32+6] = 1; m[32+7] = 1;
    m[64+16] = 1;
    return m;
  endfunction

  function automatic logic [31:0] exp_word(int w);
    logic [NL-1:0] inv = inv_lines();
    if (w < 4) return m_req[w*32 +: 32];
    if (w < 8) return m_out[(w-4)*32 +: 32] ^ ~inv[(w-4)*32 +: 32];
    return '0;
  endfunction

  task automatic chk(string tag, logic [127:0] got, logic [127:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Called in the low clock phase: read every word and the line outputs
  task automatic check_all(string tag);
    for (int w = 0; w < 16; w++) begin
      addr = 6'(w * 4 + (w % 4));
      #0.1;
      if (w < 4)      chk({tag, " R2 req word"}, 128'(rd_data), 128'(exp_word(w)));
      else if (w < 8) chk({tag, " R3 status word"}, 128'(rd_data), 128'(exp_word(w)));
      else            chk({tag, " R7 unmapped word"}, 128'(rd_data), 128'(exp_word(w)));
    end
    chk({tag, " R5 line_in_reset"}, line_in_reset, m_out);
  endtask

  // One clock: inputs applied in low phase, model stepped after the edge
  task automatic cyc(bit we, logic [5:0] a, logic [31:0] d, logic [NL-1:0] en);
    logic [NL-1:0] old_req;
    wr_en = we; addr = a; wr_data = d; line_clk_en = en;
    @(posedge clk);
    old_req = m_req;
    if (rst_n) begin
      for (int i = 0; i < NL; i++) if (en[i]) begin
        m_out[i] = m_mid[i];
        m_mid[i] = old_req[i];
      end
      if (we && a[5:2] < 4) m_req[a[5:2]*32 +: 32] = d;
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [NL-1:0] all_en;
    logic [NL-1:0] en;
    logic [31:0]   snap;
    void'($urandom(32'h5EED_1234));
    all_en = '1;

    // R1: reset state
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R1 reset");
    addr = 6'h10; #0.1;
    chk("R1 released encoding bank0", 128'(rd_data), 128'(~inv_lines() & 128'hFFFF_FFFF));

    // R5: exact two-tick completion, bank 0
    cyc(1, 6'h00, 32'hA5A5_0021, all_en);
    check_all("R2 after write");
    addr = 6'h10; #0.1;
    chk("R5 no change after write edge", 128'(rd_data), 128'(32'hFFFF_FFD6));
    cyc(0, 6'h00, 0, all_en);
    addr = 6'h10; #0.1;
    chk("R5 no change after one tick", 128'(rd_data), 128'(32'hFFFF_FFD6));
    cyc(0, 6'h00, 0, all_en);
    addr = 6'h10; #0.1;
    chk("R5 completed after two ticks", 128'(rd_data), 128'(32'hFFFF_FFD6 ^ 32'hA5A5_0021));
    check_all("R5 settle");

    // R6: gated line 40 (bank1 bit 8) never completes
    en = all_en; en[40] = 1'b0;
    cyc(1, 6'h04, 32'h0000_0100, en);
    for (int k = 0; k < 20; k++) cyc(0, 6'h00, 0, en);
    addr = 6'h14; #0.1;
    chk("R6 gated status held", 128'(rd_data[8]), 128'(1'b1));
    chk("R6 gated output held", 128'(line_in_reset[40]), 128'(1'b0));
    check_all("R6 gated");
    cyc(0, 6'h00, 0, all_en);
    cyc(0, 6'h00, 0, all_en);
    addr = 6'h14; #0.1;
    chk("R6 completes once enabled", 128'(rd_data[8]), 128'(1'b0));

    // R4: all lines held -> status equals inversion mask
    for (int b = 0; b < 4; b++) cyc(1, 6'(b * 4), 32'hFFFF_FFFF, all_en);
    cyc(0, 6'h00, 0, all_en);
    cyc(0, 6'h00, 0, all_en);
    for (int b = 0; b < 4; b++) begin
      addr = 6'(16 + b * 4); #0.1;
      chk("R4 held status polarity", 128'(rd_data), 128'(inv_lines() >> (b * 32)) & 128'hFFFF_FFFF);
    end

    // R7: writes to status and unmapped words are ignored
    cyc(1, 6'h00, 32'h1234_5678, all_en);
    addr = 6'h00; #0.1; snap = rd_data;
    cyc(1, 6'h10, 32'h0, all_en);
    cyc(1, 6'h20, 32'h0, all_en);
    cyc(1, 6'h3C, 32'hFFFF_FFFF, all_en);
    addr = 6'h00; #0.1;
    chk("R7 req word untouched", 128'(rd_data), 128'(snap));
    addr = 6'h20; #0.1;
    chk("R7 unmapped reads zero", 128'(rd_data), 128'(0));
    check_all("R7 after ignored writes");

    // R8: random traffic with random gating
    for (int k = 0; k < 2000; k++) begin
      logic [NL-1:0] ren;
      for (int i = 0; i < NL; i++) ren[i] = ($urandom % 4) != 0;
      cyc(($urandom % 2) == 1, 6'($urandom % 64), $urandom, ren);
      if (k % 4 == 0) check_all("R8 random");
      else chk("R8 random line outputs", line_in_reset, m_out);
    end

    // R1: reset mid-traffic
    rst_n = 1'b0;
    m_req = '0; m_mid = '0; m_out = '0;
    cyc(0, 6'h00, 0, all_en);
    rst_n = 1'b1;
    check_all("R1 re-reset");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule